// File: doc/BRIEF.md
# Pushbutton Power Sequencing Controller

This block decides when a small system's two supply regulators, a low-dropout regulator and a buck converter, are switched on and off. It reacts to a single active-low pushbutton, an external buck request line, a supply-present flag and a flag that says the output rail has cleared its undervoltage lockout. All delays are counted in ticks of a 1 ms strobe, so the controller runs from any fast clock.

Seven states make up the controller: hard reset, off, a power-up state entered from hard reset, a power-up state entered from off, on, a long-press shutdown state and a normal shutdown state. A short wake press starts a fixed power-up window. The LDO comes on first and the buck follows a few ticks later. Both stay on for the whole window. After that the buck follows the external request. A very long press that began while the system was powering up or running forces a hard reset, even if the press outlasts several state changes.

Top module: `pushbutton_sequencer`

## Requirements
- R1: After reset the state code is 0 (hard reset), `ldo_en` and `buck_en` are low, and `path_en` equals `supply_ok`.
- R2: A press held for WAKE_MS ticks that began in hard reset leads to state code 2. A press that began in off leads to state code 3.
- R3: In either power-up state `ldo_en` is high at once and `buck_en` rises once LAG_MS ticks have passed since entry. Both then stay high until the window ends, whatever the level of `buck_req`. `buck_en` is never high while `ldo_en` is low.
- R4: When UP_MS ticks have passed in a power-up state, the state code becomes 4 (on). In the on state `ldo_en` is high and `buck_en` follows `buck_req`.
- R5: In hard reset, a high `buck_req` drives `path_en` high. The controller moves to the on state only in the cycle after both `buck_req` and `uvlo_clear` are high, and both enables rise together. Outside hard reset `path_en` is always high.
- R6: In off, a high `buck_req` moves the controller directly to the on state (code 4) without a power-up window.
- R7: A press held OFF_MS ticks in the on state moves to state code 6 with both enables low. After DN2_MS ticks the state becomes 1 (off).
- R8: A press held HR_MS ticks that began in a power-up state or in on is a hard-reset event. If it is seen in on, in state 6 or in off, the state becomes 5 with both enables low. DN1_MS ticks later it becomes 0.
- R9: A press that began in any other state never forms a hard-reset event. A wake press needs a press begun in hard reset or off, so a button still held on return to those states does not wake the controller.
- R10: A press released before WAKE_MS ticks leaves hard reset unchanged, and its count restarts at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_ms | input | 1 | One-cycle 1 ms time strobe |
| btn_n | input | 1 | Pushbutton, low while pressed (already synchronous) |
| buck_req | input | 1 | External buck enable request |
| uvlo_clear | input | 1 | Output rail above its undervoltage threshold |
| supply_ok | input | 1 | External supply present |
| ldo_en | output | 1 | LDO enable |
| buck_en | output | 1 | Buck enable |
| path_en | output | 1 | Power path enable |
| state_code | output | 3 | Current state: 0 hard reset, 1 off, 2/3 power-up, 4 on, 5 long-press shutdown, 6 shutdown |

## Verification
Two functions can fall in the same cycle. A hard-reset event can arrive in the very cycle the normal shutdown timer expires or the buck request rises in off. Likewise, a wake press can complete just as `buck_req` and `uvlo_clear` become true in hard reset. Long random button holds, mixed with random tick gaps and random request toggles, make these coincidences happen. A bench model with the priority stated in the requirements judges each cycle: the hard-reset event beats everything, and the direct buck route beats the wake press.

// File: rtl/pseq_pkg.sv
package pseq_pkg;

   typedef enum logic [2:0] {
      PS_HRST = 3'd0,
      PS_OFF  = 3'd1,
      PS_UP1  = 3'd2,
      PS_UP2  = 3'd3,
      PS_ON   = 3'd4,
      PS_DN1  = 3'd5,
      PS_DN2  = 3'd6
   } pseq_state_e;

   function automatic logic is_powerup(pseq_state_e s);
      return (s == PS_UP1) || (s == PS_UP2);
   endfunction

   function automatic logic is_idle(pseq_state_e s);
      return (s == PS_HRST) || (s == PS_OFF);
   endfunction

   function automatic int max3(int a, int b, int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/pseq_press_track.sv
module pseq_press_track
   import pseq_pkg::*;
#(
   parameter int WAKE_MS = 400,
   parameter int OFF_MS  = 1000,
   parameter int HR_MS   = 14000
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        tick,
   input  logic        pressed,
   input  pseq_state_e st,
   output logic        wake_ev,
   output logic        off_ev,
   output logic        hr_ev
);
   localparam int CW = $clog2(HR_MS + 1);

   logic          prev_q;
   logic [CW-1:0] hold_q;
   logic          hr_ok_q;
   logic          wake_ok_q;
   logic          start;

   assign start = pressed & ~prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q    <= 1'b0;
         hold_q    <= '0;
         hr_ok_q   <= 1'b0;
         wake_ok_q <= 1'b0;
      end else begin
         prev_q <= pressed;
         if (!pressed) begin
            hold_q    <= '0;
            hr_ok_q   <= 1'b0;
            wake_ok_q <= 1'b0;
         end else begin
            if (tick && (hold_q < CW'(HR_MS)))
               hold_q <= hold_q + 1'b1;
            if (start) begin
               hr_ok_q   <= is_powerup(st) || (st == PS_ON);
               wake_ok_q <= is_idle(st);
            end else begin
               wake_ok_q <= wake_ok_q & is_idle(st);
            end
         end
      end
   end

   assign wake_ev = pressed & wake_ok_q & (hold_q >= CW'(WAKE_MS));
   assign off_ev  = pressed & (hold_q >= CW'(OFF_MS));
   assign hr_ev   = pressed & hr_ok_q & (hold_q >= CW'(HR_MS));

endmodule

// File: rtl/pseq_phase_timer.sv
module pseq_phase_timer
   import pseq_pkg::*;
#(
   parameter int UP_MS  = 5000,
   parameter int DN1_MS = 1000,
   parameter int DN2_MS = 1000,
   parameter int LAG_MS = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic restart,
   output logic up_done,
   output logic dn1_done,
   output logic dn2_done,
   output logic lag_done
);
   localparam int TMAX = max3(UP_MS, DN1_MS, DN2_MS);
   localparam int TW   = $clog2(TMAX + 1);

   logic [TW-1:0] tmr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         tmr_q <= '0;
      else if (restart)
         tmr_q <= '0;
      else if (tick && (tmr_q < TW'(TMAX)))
         tmr_q <= tmr_q + 1'b1;
   end

   assign up_done  = tmr_q >= TW'(UP_MS);
   assign dn1_done = tmr_q >= TW'(DN1_MS);
   assign dn2_done = tmr_q >= TW'(DN2_MS);

   generate
      if (LAG_MS == 0) begin : g_no_lag
         assign lag_done = 1'b1;
      end else begin : g_lag
         assign lag_done = tmr_q >= TW'(LAG_MS);
      end
   endgenerate

endmodule

// File: rtl/pseq_fsm.sv
module pseq_fsm
   import pseq_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        buck_req,
   input  logic        uvlo_clear,
   input  logic        supply_ok,
   input  logic        wake_ev,
   input  logic        off_ev,
   input  logic        hr_ev,
   input  logic        up_done,
   input  logic        dn1_done,
   input  logic        dn2_done,
   input  logic        lag_done,
   output pseq_state_e st,
   output logic        restart,
   output logic        ldo_en,
   output logic        buck_en,
   output logic        path_en
);
   pseq_state_e nxt;

   always_comb begin
      nxt = st;
      unique case (st)
         PS_HRST: begin
            if (buck_req && uvlo_clear) nxt = PS_ON;
            else if (wake_ev)           nxt = PS_UP1;
         end
         PS_OFF: begin
            if (hr_ev)         nxt = PS_DN1;
            else if (buck_req) nxt = PS_ON;
            else if (wake_ev)  nxt = PS_UP2;
         end
         PS_UP1, PS_UP2: begin
            if (up_done) nxt = PS_ON;
         end
         PS_ON: begin
            if (hr_ev)       nxt = PS_DN1;
            else if (off_ev) nxt = PS_DN2;
         end
         PS_DN1: begin
            if (dn1_done) nxt = PS_HRST;
         end
         PS_DN2: begin
            if (hr_ev)         nxt = PS_DN1;
            else if (dn2_done) nxt = PS_OFF;
         end
         default: nxt = PS_HRST;
      endcase
   end

   assign restart = (nxt != st);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= PS_HRST;
      else        st <= nxt;
   end

   assign ldo_en  = is_powerup(st) || (st == PS_ON);
   assign buck_en = (is_powerup(st) && lag_done) || ((st == PS_ON) && buck_req);
   assign path_en = supply_ok || buck_req || (st != PS_HRST);

endmodule

// File: rtl/pushbutton_sequencer.sv
module pushbutton_sequencer
   import pseq_pkg::*;
#(
   parameter int WAKE_MS = 400,
   parameter int LAG_MS  = 2,
   parameter int UP_MS   = 5000,
   parameter int OFF_MS  = 1000,
   parameter int DN2_MS  = 1000,
   parameter int HR_MS   = 14000,
   parameter int DN1_MS  = 1000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick_ms,
   input  logic       btn_n,
   input  logic       buck_req,
   input  logic       uvlo_clear,
   input  logic       supply_ok,
   output logic       ldo_en,
   output logic       buck_en,
   output logic       path_en,
   output logic [2:0] state_code
);
   generate
      if (WAKE_MS < 1) begin : g_bad_wake
         $error("WAKE_MS must be at least 1");
      end
      if (LAG_MS >= UP_MS) begin : g_bad_lag
         $error("LAG_MS must be shorter than UP_MS");
      end
      if (HR_MS <= OFF_MS || HR_MS <= WAKE_MS) begin : g_bad_hr
         $error("HR_MS must exceed OFF_MS and WAKE_MS");
      end
      if (DN1_MS < 1 || DN2_MS < 1) begin : g_bad_dn
         $error("shutdown windows must be at least 1");
      end
   endgenerate

   pseq_state_e st;
   logic wake_ev, off_ev, hr_ev;
   logic up_done, dn1_done, dn2_done, lag_done;
   logic restart;

   pseq_press_track #(
      .WAKE_MS(WAKE_MS), .OFF_MS(OFF_MS), .HR_MS(HR_MS)
   ) u_press (
      .clk(clk), .rst_n(rst_n), .tick(tick_ms), .pressed(~btn_n), .st(st),
      .wake_ev(wake_ev), .off_ev(off_ev), .hr_ev(hr_ev)
   );

   pseq_phase_timer #(
      .UP_MS(UP_MS), .DN1_MS(DN1_MS), .DN2_MS(DN2_MS), .LAG_MS(LAG_MS)
   ) u_timer (
      .clk(clk), .rst_n(rst_n), .tick(tick_ms), .restart(restart),
      .up_done(up_done), .dn1_done(dn1_done), .dn2_done(dn2_done), .lag_done(lag_done)
   );

   pseq_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .buck_req(buck_req), .uvlo_clear(uvlo_clear),
      .supply_ok(supply_ok), .wake_ev(wake_ev), .off_ev(off_ev), .hr_ev(hr_ev),
      .up_done(up_done), .dn1_done(dn1_done), .dn2_done(dn2_done), .lag_done(lag_done),
      .st(st), .restart(restart), .ldo_en(ldo_en), .buck_en(buck_en), .path_en(path_en)
   );

   assign state_code = st;

endmodule

// File: rtl/pseq_checker.sv
module pseq_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       buck_req,
   input logic       uvlo_clear,
   input logic       ldo_en,
   input logic       buck_en,
   input logic       path_en,
   input logic [2:0] state_code
);
   // R1
   legal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      state_code != 3'd7);

   // R3
   buck_needs_ldo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      buck_en |-> ldo_en);

   // R5
   direct_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_code == 3'd0 && buck_req && uvlo_clear) |=> (state_code == 3'd4));

   // R5
   path_outside_hrst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_code != 3'd0) |-> path_en);

   // R6
   off_buck_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_code == 3'd1 && buck_req) |=> (state_code == 3'd4 || state_code == 3'd5));

   // R7
   dn2_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_code == 3'd6) |=> (state_code == 3'd6 || state_code == 3'd1 || state_code == 3'd5));

   // R8
   dn1_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_code == 3'd5) |=> (state_code == 3'd5 || state_code == 3'd0));

   // R8
   dn1_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_code == 3'd5) |-> (!ldo_en && !buck_en));
endmodule

bind pushbutton_sequencer pseq_checker u_pseq_chk (
   .clk(clk), .rst_n(rst_n), .buck_req(buck_req), .uvlo_clear(uvlo_clear),
   .ldo_en(ldo_en), .buck_en(buck_en), .path_en(path_en), .state_code(state_code)
);

// File: tb/tb_pushbutton_sequencer.sv
module tb_pushbutton_sequencer;
   localparam int P_WAKE = 4;
   localparam int P_LAG  = 2;
   localparam int P_UP   = 20;
   localparam int P_OFF  = 10;
   localparam int P_DN2  = 8;
   localparam int P_HR   = 40;
   localparam int P_DN1  = 10;
   localparam int P_TMAX = 20;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick_ms = 1'b1;
   logic btn_n = 1'b1;
   logic buck_req = 1'b0;
   logic uvlo_clear = 1'b0;
   logic supply_ok = 1'b0;
   logic ldo_en, buck_en, path_en;
   logic [2:0] state_code;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   pushbutton_sequencer #(
      .WAKE_MS(P_WAKE), .LAG_MS(P_LAG), .UP_MS(P_UP), .OFF_MS(P_OFF),
      .DN2_MS(P_DN2), .HR_MS(P_HR), .DN1_MS(P_DN1)
   ) dut (
      .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .btn_n(btn_n),
      .buck_req(buck_req), .uvlo_clear(uvlo_clear), .supply_ok(supply_ok),
      .ldo_en(ldo_en), .buck_en(buck_en), .path_en(path_en), .state_code(state_code)
   );

   // bench model of the requirements
   int m_st, m_cnt, m_tmr, m_nx;
   bit m_pq, m_hre, m_wke;

   function automatic bit f_ldo(int s);
      return (s == 2) || (s == 3) || (s == 4);
   endfunction
   function automatic bit f_buck(int s, int t, bit req);
      return ((s == 2 || s == 3) && t >= P_LAG) || (s == 4 && req);
   endfunction
   function automatic bit f_path(int s, bit sup, bit req);
      return sup || req || (s != 0);
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_st = 0; m_cnt = 0; m_tmr = 0; m_pq = 0; m_hre = 0; m_wke = 0;
      end else begin
         bit p, st_ok, hr, wk, of;
         p  = !btn_n;
         hr = p && m_hre && m_cnt >= P_HR;
         wk = p && m_wke && m_cnt >= P_WAKE;
         of = p && m_cnt >= P_OFF;
         m_nx = m_st;
         case (m_st)
            0: if (buck_req && uvlo_clear) m_nx = 4; else if (wk) m_nx = 2;
            1: if (hr) m_nx = 5; else if (buck_req) m_nx = 4; else if (wk) m_nx = 3;
            2, 3: if (m_tmr >= P_UP) m_nx = 4;
            4: if (hr) m_nx = 5; else if (of) m_nx = 6;
            5: if (m_tmr >= P_DN1) m_nx = 0;
            6: if (hr) m_nx = 5; else if (m_tmr >= P_DN2) m_nx = 1;
            default: m_nx = 0;
         endcase
         st_ok = p && !m_pq;
         if (!p) begin
            m_hre = 0; m_wke = 0;
         end else if (st_ok) begin
            m_hre = (m_st == 2 || m_st == 3 || m_st == 4);
            m_wke = (m_st == 0 || m_st == 1);
         end else begin
            m_wke = m_wke && (m_st == 0 || m_st == 1);
         end
         if (!p) m_cnt = 0;
         else if (tick_ms && m_cnt < P_HR) m_cnt++;
         if (m_nx != m_st) m_tmr = 0;
         else if (tick_ms && m_tmr < P_TMAX) m_tmr++;
         m_pq = p;
         m_st = m_nx;
      end
   end

   task automatic chk(string req, int act, int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // every-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R8 state", int'(state_code), m_st);
         chk("R3 ldo_en", int'(ldo_en), int'(f_ldo(m_st)));
         chk("R4 buck_en", int'(buck_en), int'(f_buck(m_st, m_tmr, buck_req)));
         chk("R5 path_en", int'(path_en), int'(f_path(m_st, supply_ok, buck_req)));
      end
   end

   task automatic step(int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic wait_code(int code, int lim, output int n);
      n = 0;
      while (int'(state_code) != code && n < lim) begin
         @(negedge clk);
         n++;
      end
      #1;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(8 * 190000);
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      finish_run();
   end

   initial begin
      int n;
      void'($urandom(32'd20240611));
      step(3);
      #1;
      // R1 reset state
      chk("R1 state", int'(state_code), 0);
      chk("R1 ldo", int'(ldo_en), 0);
      chk("R1 buck", int'(buck_en), 0);
      chk("R1 path", int'(path_en), 0);
      rst_n = 1'b1;
      step(2);

      // R10 short press ignored
      btn_n = 1'b0; step(P_WAKE - 2); btn_n = 1'b1; step(6);
      chk("R10 state", int'(state_code), 0);

      // R2 wake from hard reset, R3 staggered enables
      btn_n = 1'b0;
      wait_code(2, 30, n);
      chk("R2 up1", int'(state_code), 2);
      chk("R3 ldo first", int'(ldo_en), 1);
      chk("R3 buck lags", int'(buck_en), 0);
      step(1); btn_n = 1'b1; buck_req = 1'b0;
      step(6); #2;
      chk("R3 buck in window", int'(buck_en), 1);
      wait_code(4, 40, n);
      chk("R4 on", int'(state_code), 4);
      chk("R4 buck off", int'(buck_en), 0);
      chk("R4 ldo kept", int'(ldo_en), 1);
      step(1); buck_req = 1'b1; step(1); #2;
      chk("R4 buck follows", int'(buck_en), 1);

      // R7 power down
      buck_req = 1'b0; btn_n = 1'b0;
      wait_code(6, 30, n);
      chk("R7 dn2", int'(state_code), 6);
      chk("R7 dark", int'(ldo_en) + int'(buck_en), 0);
      step(1); btn_n = 1'b1;
      wait_code(1, 30, n);
      chk("R7 off", int'(state_code), 1);

      // R2 wake from off
      step(2); btn_n = 1'b0;
      wait_code(3, 30, n);
      chk("R2 up2", int'(state_code), 3);
      step(1); btn_n = 1'b1;
      wait_code(4, 40, n);
      step(1); btn_n = 1'b0;
      wait_code(6, 30, n);
      step(1); btn_n = 1'b1;
      wait_code(1, 30, n);

      // R6 buck request in off
      step(1); buck_req = 1'b1; step(1); #2;
      chk("R6 direct on", int'(state_code), 4);
      buck_req = 1'b0;

      // R8 long press started in on
      step(1); btn_n = 1'b0;
      wait_code(5, 80, n);
      chk("R8 dn1", int'(state_code), 5);
      wait_code(0, 30, n);
      chk("R8 hrst", int'(state_code), 0);
      step(10); #2;
      chk("R9 held no wake", int'(state_code), 0);
      btn_n = 1'b1; step(2);

      // R5 buck request from hard reset waits for uvlo
      buck_req = 1'b1; step(5); #2;
      chk("R5 path", int'(path_en), 1);
      chk("R5 wait uvlo", int'(state_code), 0);
      uvlo_clear = 1'b1; step(1); #2;
      chk("R5 on", int'(state_code), 4);
      chk("R5 together", int'(ldo_en) + int'(buck_en), 2);

      // R9 press begun in off never forms a hard-reset event
      buck_req = 1'b0; step(1); btn_n = 1'b0;
      wait_code(6, 30, n); step(1); btn_n = 1'b1;
      wait_code(1, 30, n); step(2);
      btn_n = 1'b0; step(70); #2;
      chk("R9 no hr", int'(state_code), 1);
      btn_n = 1'b1; step(3);

      // random phase
      begin
         int hold = 0;
         for (int i = 0; i < 40000; i++) begin
            if (hold == 0) begin
               btn_n = ($urandom % 3) != 0;
               hold = btn_n ? int'($urandom_range(1, 30)) : int'($urandom_range(1, 70));
            end else hold--;
            tick_ms = ($urandom % 4) != 0;
            if ($urandom % 40 == 0) buck_req = ~buck_req;
            if ($urandom % 30 == 0) uvlo_clear = ~uvlo_clear;
            if ($urandom % 50 == 0) supply_ok = ~supply_ok;
            step(1);
         end
      end
      step(2);
      finish_run();
   end

endmodule